// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit runs one integer operation across every lane of two 128-bit operands in a single issue. A 2-bit size field splits each operand into sixteen 8-bit, eight 16-bit or four 32-bit lanes. Every lane computes independently. The operations are wrapping add and subtract, signed or unsigned minimum and maximum, four bitwise functions, three shifts, and a per-lane count of leading zeros. A separate funnel operation treats the two operands as one 256-bit value and returns a 128-bit slice of it.

The datapath is split into two 64-bit halves. Each half holds lane units for all three lane sizes and picks one set of results according to the size field. The funnel shifter sits beside the two halves. A single output register captures the chosen result together with a valid flag. An issuing stage drives the operands, the opcode, the size, the compare mode and the shift amount with `in_valid` high, and it reads `result` on the following cycle.

Top module: `simd_alu`

## Requirements
- R1: `lane_sel` picks the lane size: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Opcode 0 (add) and opcode 1 (subtract, `src_a - src_b`) wrap modulo the lane width, and no carry or borrow moves into a neighbouring lane.
- R2: Opcode 2 (minimum) and opcode 3 (maximum) pick `src_a` or `src_b` per lane. They compare as two's complement when `signed_cmp` is 1 and as unsigned when it is 0.
- R3: Opcode 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) combine `src_a` with `src_b` bit by bit. The result does not depend on `lane_sel`.
- R4: Opcode 8 (left shift), 9 (logical right shift) and 10 (arithmetic right shift) shift each lane of `src_a` by `shamt` modulo the lane width. Zeros fill from the right for opcode 8 and from the left for opcode 9. For opcode 10 the lane's sign bit fills from the left.
- R5: Opcode 11 writes into each lane the number of leading zero bits of that lane of `src_a`. A lane that is all zeros gives the lane width: 8, 16 or 32.
- R6: Opcode 12 (funnel) returns bits `shamt+127` down to `shamt` of the 256-bit value `{src_b, src_a}`. `shamt` runs from 0 to 127, and a shift of 0 returns `src_a` unchanged. This operation ignores `lane_sel`.
- R7: Opcodes 13, 14 and 15 produce an all-zero result.
- R8: When `in_valid` is high at a rising clock edge, `result` and `out_valid` (high) change at that same edge, so they appear one cycle after the issue.
- R9: When `in_valid` is low at a rising clock edge, `result` keeps its value and `out_valid` goes low.
- R10: A synchronous active-low reset clears `result` to zero and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operation on the inputs |
| opcode | input | 4 | Operation code (see R1 to R7) |
| lane_sel | input | 2 | Lane size select |
| signed_cmp | input | 1 | Two's complement compare for minimum and maximum |
| shamt | input | 7 | Shift amount for lane shifts and the funnel |
| src_a | input | 128 | First operand, lower half of the funnel value |
| src_b | input | 128 | Second operand, upper half of the funnel value |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 128 | Registered result |

## Verification
Two functions meet in one add: a lane wraps past its top, and its neighbour's value must stay exactly as it was. The bench triggers this with all-ones lanes plus one at each lane size. In that case every lane has to read zero, with no bit carried across the boundary, and this includes the boundary at bit 64 between the two halves. The register's capture-and-hold behaviour is exercised by alternating back-to-back issues with idle cycles that carry junk operands. An idle cycle passes only if `result` keeps the last issued value.

// File: rtl/simd_alu_pkg.sv
// Package: shared opcodes, lane-size codes and lane geometry for the packed ALU.
// Assumes every lane size is a power of two, starting at LANE_MIN_W and doubling.
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MIN  = 4'd2,
        OP_MAX  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_CLZ  = 4'd11,
        OP_FUNL = 4'd12
    } simd_op_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2
    } lane_sel_e;

    localparam int LANE_MIN_W   = 8;
    localparam int N_LANE_SIZES = 3;
    localparam int LANE_MAX_W   = LANE_MIN_W << (N_LANE_SIZES - 1);
    localparam int LANE_AMT_W   = $clog2(LANE_MAX_W);

endpackage

// File: rtl/simd_lane_op.sv
// Module: one lane of width W. It does arithmetic, compare, logic, shift and
// leading-zero count, all combinationally.
// Assumes W is a power of two. The shift amount is already reduced to log2(W) bits.
// Funnel and unassigned opcodes give zero here; the top module handles the funnel.
module simd_lane_op
    import simd_alu_pkg::*;
#(
    parameter int W = 8,
    localparam int SW = $clog2(W),
    localparam int CW = $clog2(W + 1)
) (
    input  simd_op_e       op,
    input  logic           signed_cmp,
    input  logic [SW-1:0]  amt,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    logic          a_lt_b;
    logic [CW-1:0] lead0;

    // Compare a against b in the selected number format.
    always_comb begin
        if (signed_cmp) a_lt_b = ($signed(a) < $signed(b));
        else            a_lt_b = (a < b);
    end

    // Count leading zeros: the highest set bit wins, and an all-zero lane gives W.
    always_comb begin
        lead0 = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) lead0 = CW'(W - 1 - i);
        end
    end

    // Choose the lane result by opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MIN:  y = a_lt_b ? a : b;
            OP_MAX:  y = a_lt_b ? b : a;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_SLL:  y = a << amt;
            OP_SRL:  y = a >> amt;
            OP_SRA:  y = W'($signed(a) >>> amt);
            OP_CLZ:  y = W'(lead0);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_half.sv
// Module: one 64-bit half of the packed datapath. It holds lane units for every
// lane size and selects the set that lane_sel asks for.
// Assumes HALF_W is a multiple of the largest lane width.
module simd_half
    import simd_alu_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  simd_op_e              op,
    input  lane_sel_e             lane_sel,
    input  logic                  signed_cmp,
    input  logic [LANE_AMT_W-1:0] amt,
    input  logic [HALF_W-1:0]     a,
    input  logic [HALF_W-1:0]     b,
    output logic [HALF_W-1:0]     y
);

    logic [N_LANE_SIZES-1:0][HALF_W-1:0] by_size;

    for (genvar k = 0; k < N_LANE_SIZES; k++) begin : g_size
        localparam int LW = LANE_MIN_W << k;
        localparam int LN = HALF_W / LW;
        localparam int LS = $clog2(LW);
        for (genvar j = 0; j < LN; j++) begin : g_lane
            simd_lane_op #(.W(LW)) u_lane (
                .op         (op),
                .signed_cmp (signed_cmp),
                .amt        (amt[LS-1:0]),
                .a          (a[j*LW +: LW]),
                .b          (b[j*LW +: LW]),
                .y          (by_size[k][j*LW +: LW])
            );
        end
    end

    // Take the results of the selected lane partition; code 3 acts as 32-bit.
    always_comb begin
        case (lane_sel)
            LANE_8:  y = by_size[0];
            LANE_16: y = by_size[1];
            default: y = by_size[N_LANE_SIZES-1];
        endcase
    end

endmodule

// File: rtl/simd_funnel.sv
// Module: funnel shifter. It returns the W-bit window of {hi, lo} that starts
// at bit position amt.
// Assumes amt has log2(W) bits, so the window always fits inside the 2W-bit value.
module simd_funnel #(
    parameter int W = 128,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  lo,
    input  logic [W-1:0]  hi,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  y
);

    logic [2*W-1:0] joined;

    // Join the two halves and shift right; the low W bits are the window.
    always_comb begin
        joined = {hi, lo} >> amt;
        y      = joined[W-1:0];
    end

endmodule

// File: rtl/simd_alu.sv
// Module: top of the packed SIMD integer ALU. Two 64-bit halves and a funnel
// shifter feed one output register.
// Assumes DATA_W equals two halves and each half is a multiple of the largest lane.
// The register takes a new result only on in_valid and holds it otherwise.
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 128,
    localparam int N_HALF = 2,
    localparam int HALF_W = DATA_W / N_HALF,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         opcode,
    input  logic [1:0]         lane_sel,
    input  logic               signed_cmp,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result
);

    simd_op_e            op_e;
    lane_sel_e           lane_e;
    logic [DATA_W-1:0]   lane_res;
    logic [DATA_W-1:0]   funnel_res;
    logic [DATA_W-1:0]   next_res;

    assign op_e   = simd_op_e'(opcode);
    assign lane_e = lane_sel_e'(lane_sel);

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        simd_half #(.HALF_W(HALF_W)) u_half (
            .op         (op_e),
            .lane_sel   (lane_e),
            .signed_cmp (signed_cmp),
            .amt        (shamt[LANE_AMT_W-1:0]),
            .a          (src_a[h*HALF_W +: HALF_W]),
            .b          (src_b[h*HALF_W +: HALF_W]),
            .y          (lane_res[h*HALF_W +: HALF_W])
        );
    end

    simd_funnel #(.W(DATA_W)) u_funnel (
        .lo  (src_a),
        .hi  (src_b),
        .amt (shamt),
        .y   (funnel_res)
    );

    // Route the funnel result when the funnel opcode is issued, else the lane results.
    always_comb begin
        next_res = (op_e == OP_FUNL) ? funnel_res : lane_res;
    end

    // Output register: capture on issue, hold when idle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    // R8: an issue gives a valid result on the next cycle.
    p_issue_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: an idle cycle keeps the result and lowers the valid flag.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && !out_valid));

    // R6: a funnel shift of zero returns the lower operand.
    p_funnel_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd12 && shamt == '0) |=> (result == $past(src_a)));

    // R5: an all-zero 32-bit lane counts to 32.
    p_clz_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd11 && lane_sel == 2'd2 && src_a[31:0] == '0)
        |=> (result[31:0] == 32'd32));

    // R3: XOR does not depend on lane partitioning.
    p_xor_flat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd6) |=> (result == ($past(src_a) ^ $past(src_b))));

    // R7: unassigned opcodes give zero.
    p_bad_op_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode > 4'd12) |=> (result == '0));

endmodule

// File: tb/sim_simd_alu.sv
module sim_simd_alu;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [3:0]   opcode;
    logic [1:0]   lane_sel;
    logic         signed_cmp;
    logic [6:0]   shamt;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .lane_sel(lane_sel), .signed_cmp(signed_cmp), .shamt(shamt),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    // Reference model built from the requirements.
    function automatic logic [127:0] model(logic [3:0] op, logic [1:0] ls, logic sc,
                                           logic [6:0] sh, logic [127:0] a, logic [127:0] b);
        logic [127:0] r;
        logic [255:0] cat;
        int lw;
        int s;
        logic [31:0] mask;
        r = '0;
        if (op == 4'd12) begin
            cat = {b, a} >> sh;
            return cat[127:0];
        end
        if (op > 4'd12) return '0;
        lw   = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        mask = 32'hFFFF_FFFF >> (32 - lw);
        s    = int'(sh) % lw;
        for (int i = 0; i < 128 / lw; i++) begin
            logic [31:0] x, y, z;
            longint xv, yv, t;
            int cnt;
            x = 32'(a >> (i * lw)) & mask;
            y = 32'(b >> (i * lw)) & mask;
            xv = longint'(x);
            yv = longint'(y);
            if (sc && x[lw-1]) xv = xv - (longint'(1) << lw);
            if (sc && y[lw-1]) yv = yv - (longint'(1) << lw);
            case (op)
                4'd0: z = (x + y) & mask;
                4'd1: z = (x - y) & mask;
                4'd2: z = (xv < yv) ? x : y;
                4'd3: z = (xv < yv) ? y : x;
                4'd4: z = x & y;
                4'd5: z = x | y;
                4'd6: z = x ^ y;
                4'd7: z = ~(x | y) & mask;
                4'd8: z = (x << s) & mask;
                4'd9: z = x >> s;
                4'd10: begin
                    t = longint'(x);
                    if (x[lw-1]) t = t - (longint'(1) << lw);
                    t = t >>> s;
                    z = 32'(t) & mask;
                end
                default: begin
                    cnt = lw;
                    for (int j = 0; j < lw; j++) if (x[j]) cnt = lw - 1 - j;
                    z = 32'(cnt);
                end
            endcase
            r = r | (128'(z) << (i * lw));
        end
        return r;
    endfunction

    function automatic string req_of(logic [3:0] op);
        if (op <= 4'd1)  return "R1";
        if (op <= 4'd3)  return "R2";
        if (op <= 4'd7)  return "R3";
        if (op <= 4'd10) return "R4";
        if (op == 4'd11) return "R5";
        if (op == 4'd12) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation, then sample after the capturing edge.
    task automatic issue(logic [3:0] o, logic [1:0] l, logic sc, logic [6:0] sh,
                         logic [127:0] a, logic [127:0] b);
        logic [127:0] e;
        e = model(o, l, sc, sh, a, b);
        opcode = o; lane_sel = l; signed_cmp = sc; shamt = sh;
        src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        check(req_of(o), result, e);
        check("R8", {127'b0, out_valid}, 128'd1);
    endtask

    // Idle cycle with junk on the inputs: the result must hold.
    task automatic idle();
        logic [127:0] prev;
        prev = result;
        in_valid = 1'b0;
        opcode = 4'($urandom); lane_sel = 2'($urandom); shamt = 7'($urandom);
        src_a = {$urandom, $urandom, $urandom, $urandom};
        src_b = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        check("R9", result, prev);
        check("R9", {127'b0, out_valid}, 128'd0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] ones, r1, r2;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b1; opcode = 4'd5; lane_sel = 2'd0;
        signed_cmp = 1'b0; shamt = '0; src_a = '1; src_b = '1;
        repeat (3) @(negedge clk);
        check("R10", result, '0);
        check("R10", {127'b0, out_valid}, 128'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        ones = '1;
        // R1: wrap inside each lane with no carry across lanes, all sizes
        issue(4'd0, 2'd0, 1'b0, 7'd0, ones, {16{8'h01}});
        issue(4'd0, 2'd1, 1'b0, 7'd0, ones, {8{16'h0001}});
        issue(4'd0, 2'd2, 1'b0, 7'd0, ones, {4{32'h1}});
        issue(4'd1, 2'd1, 1'b0, 7'd0, '0, {8{16'h0001}});
        issue(4'd0, 2'd3, 1'b0, 7'd0, {4{32'h7FFF_FFFF}}, {4{32'h1}});
        // R2: signed and unsigned compares disagree on 0x80 versus 0x01
        issue(4'd2, 2'd0, 1'b1, 7'd0, {16{8'h80}}, {16{8'h01}});
        issue(4'd2, 2'd0, 1'b0, 7'd0, {16{8'h80}}, {16{8'h01}});
        issue(4'd3, 2'd2, 1'b1, 7'd0, {4{32'hFFFF_FFFF}}, {4{32'h2}});
        issue(4'd3, 2'd2, 1'b0, 7'd0, {4{32'hFFFF_FFFF}}, {4{32'h2}});
        // R3: NOR is flat
        issue(4'd7, 2'd1, 1'b0, 7'd0, {32{4'hA}}, {32{4'h3}});
        // R4: shift amount taken modulo lane width
        issue(4'd8, 2'd0, 1'b0, 7'd9, {16{8'h81}}, '0);
        issue(4'd10, 2'd1, 1'b0, 7'd15, {8{16'h8000}}, '0);
        issue(4'd9, 2'd2, 1'b0, 7'd33, {4{32'h8000_0000}}, '0);
        // R5: all-zero lanes and top-bit lanes
        issue(4'd11, 2'd0, 1'b0, 7'd0, '0, '0);
        issue(4'd11, 2'd1, 1'b0, 7'd0, '0, '0);
        issue(4'd11, 2'd2, 1'b0, 7'd0, {32'h8000_0000, 32'h1, 32'h0001_0000, 32'h0}, '0);
        // R6: funnel boundaries
        r1 = {$urandom, $urandom, $urandom, $urandom};
        r2 = {$urandom, $urandom, $urandom, $urandom};
        issue(4'd12, 2'd0, 1'b0, 7'd0, r1, r2);
        check("R6", result, r1);
        issue(4'd12, 2'd1, 1'b0, 7'd127, r1, r2);
        issue(4'd12, 2'd2, 1'b0, 7'd64, r1, r2);
        // R7: unassigned code
        issue(4'd14, 2'd2, 1'b0, 7'd3, ones, ones);
        // R9: hold through idle cycles
        issue(4'd6, 2'd0, 1'b0, 7'd0, r1, r2);
        idle();
        idle();

        for (int n = 0; n < 600; n++) begin
            if (($urandom % 8) == 0) idle();
            else issue(4'($urandom), 2'($urandom), 1'($urandom), 7'($urandom),
                       {$urandom, $urandom, $urandom, $urandom},
                       {$urandom, $urandom, $urandom, $urandom});
        end

        // R10: reset in mid-run clears a non-zero result
        issue(4'd5, 2'd0, 1'b0, 7'd0, ones, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", result, '0);
        check("R10", {127'b0, out_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule